// File: doc/BRIEF.md
# Two-Slot Serial-Bus Byte Buffer Pair with Held Flush

This block sits between a register-mapped host port and the byte engine of a two-wire serial controller. It holds two independent two-byte queues. The outbound queue is loaded by host writes and drained by the bus engine. The inbound queue is filled by the bus engine and drained by host reads. Both queues keep bytes in arrival order. A five-bit control word sets how each queue behaves, and the word works the same way whether the controller acts as bus master or as slave.

Each queue reports a two-bit fill level and drives a level interrupt. A per-queue length bit sets whether that interrupt fires at a one-byte threshold or a two-byte threshold. A flush bit per queue is a held level, not a pulse. While the outbound flush is held, that queue discards its contents and tells the engine it has nothing to send. While the inbound flush is held, that queue discards its contents and tells the engine it is full, so it takes no new byte. When the inbound queue fills up, a hang-disable bit selects the response. With the bit clear, the queue stalls the engine. With the bit set, each new byte overwrites the oldest one. A host write to a full outbound queue is dropped and sets a sticky error flag. A host read from an empty inbound queue is dropped the same way and sets its own sticky error flag.

Top module: `sbf_pair`

## Requirements
- R1: After reset both levels read 00, the control word reads 0, both error flags are 0, tx_irq is 1, rx_irq is 0, and eng_rx_stall and eng_rx_full are 0.
- R2: A cycle with ctl_wr high loads control bits [4:0] from ctl_wdata. The bits are: bit 0 outbound flush, bit 1 inbound flush, bit 2 outbound interrupt length, bit 3 inbound interrupt length, bit 4 hang disable. ctl_rdata shows them on the next cycle, and bits 15..5 always read 0.
- R3: The outbound level reads 00 with no bytes, 01 with one byte and 11 with two. eng_tx_data shows the oldest byte written (0 when eng_tx_valid is low). eng_tx_pop removes that byte.
- R4: With bit 2 at 0, tx_irq is high when the outbound level is 00 or 01. With bit 2 at 1, tx_irq is high only at 00.
- R5: While bit 0 is 1, the outbound level reads 00, eng_tx_valid is 0, and host writes and engine pops have no effect. After bit 0 returns to 0 the queue is empty and accepts new bytes.
- R6: A host write while the outbound queue holds two bytes leaves the contents unchanged and sets tx_err. tx_err stays set until reset.
- R7: The inbound level uses the same codes (00, 01, 11). host_rx_data shows the oldest stored byte (0 when empty), and host_rx_rd removes it.
- R8: With bit 3 at 0, rx_irq is high when the inbound level is 01 or 11. With bit 3 at 1, rx_irq is high only at 11.
- R9: While bit 1 is 1, the inbound level reads 00, eng_rx_full is 1, eng_rx_stall is 0, and engine pushes are dropped. After bit 1 returns to 0 the queue is empty.
- R10: A host read while the inbound queue is empty changes nothing and sets rx_err. rx_err stays set until reset.
- R11: With bit 4 at 0 and two inbound bytes held, eng_rx_stall and eng_rx_full are 1 and an engine push leaves the contents unchanged.
- R12: With bit 4 at 1 and two inbound bytes held, eng_rx_stall is 0, eng_rx_full is 1, and an engine push drops the oldest byte and appends the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word readback |
| host_tx_wr | input | 1 | Host push into outbound queue |
| host_tx_data | input | 8 | Byte written by host |
| host_rx_rd | input | 1 | Host pop from inbound queue |
| host_rx_data | output | 8 | Oldest inbound byte |
| eng_tx_pop | input | 1 | Engine takes the oldest outbound byte |
| eng_tx_valid | output | 1 | Outbound byte available to engine |
| eng_tx_data | output | 8 | Oldest outbound byte |
| eng_rx_push | input | 1 | Engine delivers an inbound byte |
| eng_rx_data | input | 8 | Byte delivered by engine |
| eng_rx_full | output | 1 | Inbound queue answers full |
| eng_rx_stall | output | 1 | Engine must hold its byte |
| tx_level | output | 2 | Outbound fill code |
| rx_level | output | 2 | Inbound fill code |
| tx_irq | output | 1 | Outbound interrupt level |
| rx_irq | output | 1 | Inbound interrupt level |
| tx_err | output | 1 | Sticky write-when-full flag |
| rx_err | output | 1 | Sticky read-when-empty flag |

## Verification
The bench targets several corner cases and the fault each one would reveal. It fills the inbound queue with hang enabled, then pushes again: a design that stalls wrongly would change or drop a stored byte. It repeats the push with hang disabled, where a design without overwrite would keep the stale head instead of shifting in the new byte. It holds each flush across writes, pops and pushes, then checks that the queue comes back empty and that the engine saw "empty" on the outbound side and "full" on the inbound side. A design that treats flush as a one-cycle pulse, or that inverts the two answers, fails here. It also writes to a full queue, reads from an empty one and switches the length bits, which shows a lost error flag or an interrupt threshold that is one level off.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

   // control word, bit 0 at the bottom
   typedef struct packed {
      logic hang_off;   // bit 4
      logic rx_len2;    // bit 3
      logic tx_len2;    // bit 2
      logic rx_flush;   // bit 1
      logic tx_flush;   // bit 0
   } sbf_ctl_t;

   localparam int unsigned CTL_USED = $bits(sbf_ctl_t);

   localparam logic [1:0] LVL_EMPTY = 2'b00;
   localparam logic [1:0] LVL_ONE   = 2'b01;
   localparam logic [1:0] LVL_FULL  = 2'b11;

   function automatic logic [1:0] lvl_code(input logic hidden,
                                           input logic none,
                                           input logic all);
      if (hidden || none) return LVL_EMPTY;
      else if (all)       return LVL_FULL;
      else                return LVL_ONE;
   endfunction

endpackage

// File: rtl/sbf_ctl_reg.sv
module sbf_ctl_reg
   import sbf_pkg::*;
#(
   parameter int unsigned CTL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output sbf_ctl_t         ctl,
   output logic [CTL_W-1:0] rdata
);

   initial begin
      assert (CTL_W >= CTL_USED) else $error("control word too narrow");
   end

   sbf_ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl_q <= '0;
      else if (wr) ctl_q <= sbf_ctl_t'(wdata[CTL_USED-1:0]);
   end

   assign ctl = ctl_q;

   generate
      if (CTL_W > CTL_USED) begin : g_pad
         assign rdata = {{(CTL_W-CTL_USED){1'b0}}, ctl_q};
      end else begin : g_nopad
         assign rdata = ctl_q;
      end
   endgenerate

   // R2: written value appears on the readback one cycle later
   a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> rdata[CTL_USED-1:0] == $past(wdata[CTL_USED-1:0]))
      else $error("control load mismatch");

endmodule

// File: rtl/sbf_ring.sv
module sbf_ring #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SLOTS  = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clr,
   input  logic                              push,
   input  logic                              pop,
   input  logic [DATA_W-1:0]                 din,
   output logic [DATA_W-1:0]                 head,
   output logic [$clog2(SLOTS+1)-1:0]        cnt
);

   localparam int unsigned CNT_W = $clog2(SLOTS+1);

   initial begin
      assert (SLOTS >= 2) else $error("ring needs at least two slots");
      assert (DATA_W >= 1) else $error("ring data width must be positive");
   end

   logic [DATA_W-1:0] slot_q  [SLOTS];
   logic [DATA_W-1:0] shifted [SLOTS];
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  wr_idx;

   // next-younger slot for each position, zero behind the tail
   generate
      for (genvar g = 0; g < SLOTS; g++) begin : g_shift
         if (g < SLOTS-1) begin : g_mid
            assign shifted[g] = slot_q[g+1];
         end else begin : g_tail
            assign shifted[g] = '0;
         end
      end
   endgenerate

   assign wr_idx = cnt_q - CNT_W'(pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
      end else begin
         for (int i = 0; i < SLOTS; i++) begin
            if (push && wr_idx == CNT_W'(i)) slot_q[i] <= din;
            else if (pop)                    slot_q[i] <= shifted[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q - CNT_W'(pop) + CNT_W'(push);
   end

   assign head = slot_q[0];
   assign cnt  = cnt_q;

   // R3 / R7: callers never over- or under-run the storage
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q - CNT_W'(pop)) < CNT_W'(SLOTS))
      else $error("push into full ring");

   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt_q != '0)
      else $error("pop from empty ring");

   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(SLOTS))
      else $error("ring count out of range");

endmodule

// File: rtl/sbf_tx_side.sv
module sbf_tx_side
   import sbf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SLOTS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              len2,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_data,
   input  logic              eng_pop,
   output logic              eng_valid,
   output logic [DATA_W-1:0] eng_head,
   output logic [1:0]        level,
   output logic              irq,
   output logic              err
);

   localparam int unsigned CNT_W = $clog2(SLOTS+1);

   logic [CNT_W-1:0] cnt;
   logic             full, none, wr_ok, pop_ok, err_q;

   assign full   = (cnt == CNT_W'(SLOTS));
   assign none   = (cnt == '0);
   assign wr_ok  = host_wr && !flush && !full;
   assign pop_ok = eng_pop && !flush && !none;

   sbf_ring #(.DATA_W(DATA_W), .SLOTS(SLOTS)) ring_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (flush),
      .push (wr_ok),
      .pop  (pop_ok),
      .din  (host_data),
      .head (eng_head),
      .cnt  (cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          err_q <= 1'b0;
      else if (host_wr && !flush && full)  err_q <= 1'b1;
   end

   assign err       = err_q;
   assign eng_valid = !flush && !none;
   assign level     = lvl_code(flush, none, full);
   assign irq       = len2 ? (level == LVL_EMPTY) : (level != LVL_FULL);

   // R6: a write into a full queue is flagged and the flag sticks
   a_r6_full_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !flush && full) |=> err)
      else $error("full write not flagged");

   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err)
      else $error("tx error flag dropped");

   a_r6_full_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
      (full && host_wr && !eng_pop && !flush) |=> (eng_head == $past(eng_head)) && full)
      else $error("full write disturbed contents");

   // R5: a held flush leaves nothing behind
   a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> none)
      else $error("tx flush left data");

endmodule

// File: rtl/sbf_rx_side.sv
module sbf_rx_side
   import sbf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SLOTS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              len2,
   input  logic              hang_off,
   input  logic              eng_push,
   input  logic [DATA_W-1:0] eng_data,
   input  logic              host_rd,
   output logic              host_valid,
   output logic [DATA_W-1:0] host_head,
   output logic [1:0]        level,
   output logic              irq,
   output logic              err,
   output logic              eng_full,
   output logic              eng_stall
);

   localparam int unsigned CNT_W = $clog2(SLOTS+1);

   logic [CNT_W-1:0] cnt;
   logic             full, none, rd_ok, accept, overwrite, err_q;

   assign full      = (cnt == CNT_W'(SLOTS));
   assign none      = (cnt == '0);
   assign rd_ok     = host_rd && !flush && !none;
   assign accept    = eng_push && !flush && (!full || hang_off);
   assign overwrite = accept && full && !rd_ok;

   sbf_ring #(.DATA_W(DATA_W), .SLOTS(SLOTS)) ring_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (flush),
      .push (accept),
      .pop  (rd_ok || overwrite),
      .din  (eng_data),
      .head (host_head),
      .cnt  (cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       err_q <= 1'b0;
      else if (host_rd && !rd_ok)       err_q <= 1'b1;
   end

   assign err        = err_q;
   assign host_valid = !flush && !none;
   assign eng_full   = flush || full;
   assign eng_stall  = !flush && full && !hang_off;
   assign level      = lvl_code(flush, none, full);
   assign irq        = len2 ? (level == LVL_FULL) : (level != LVL_EMPTY);

   // R11: a stalled push changes nothing
   a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_stall && eng_push && !host_rd) |=> full && (host_head == $past(host_head)))
      else $error("stalled push altered contents");

   // R12: overwrite keeps the queue full
   a_r12_overwrite_full: assert property (@(posedge clk) disable iff (!rst_n)
      (hang_off && full && eng_push && !flush && !host_rd) |=> full)
      else $error("overwrite lost occupancy");

   // R10: an empty read is flagged
   a_r10_empty_read_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && none) |=> err)
      else $error("empty read not flagged");

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err)
      else $error("rx error flag dropped");

   // R9: a held flush leaves nothing behind
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> none)
      else $error("rx flush left data");

endmodule

// File: rtl/sbf_pair.sv
module sbf_pair
   import sbf_pkg::*;
#(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned CTL_W           = 16,
   parameter int unsigned SLOTS           = 2,
   parameter bit          ZERO_WHEN_EMPTY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   input  logic              host_tx_wr,
   input  logic [DATA_W-1:0] host_tx_data,
   input  logic              host_rx_rd,
   output logic [DATA_W-1:0] host_rx_data,
   input  logic              eng_tx_pop,
   output logic              eng_tx_valid,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_rx_push,
   input  logic [DATA_W-1:0] eng_rx_data,
   output logic              eng_rx_full,
   output logic              eng_rx_stall,
   output logic [1:0]        tx_level,
   output logic [1:0]        rx_level,
   output logic              tx_irq,
   output logic              rx_irq,
   output logic              tx_err,
   output logic              rx_err
);

   initial begin
      assert (SLOTS == 2) else $error("two-bit level code needs exactly two slots");
   end

   sbf_ctl_t          ctl;
   logic [DATA_W-1:0] tx_head, rx_head;
   logic              rx_valid;

   sbf_ctl_reg #(.CTL_W(CTL_W)) ctl_i (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (ctl_wr),
      .wdata(ctl_wdata),
      .ctl  (ctl),
      .rdata(ctl_rdata)
   );

   sbf_tx_side #(.DATA_W(DATA_W), .SLOTS(SLOTS)) tx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (ctl.tx_flush),
      .len2     (ctl.tx_len2),
      .host_wr  (host_tx_wr),
      .host_data(host_tx_data),
      .eng_pop  (eng_tx_pop),
      .eng_valid(eng_tx_valid),
      .eng_head (tx_head),
      .level    (tx_level),
      .irq      (tx_irq),
      .err      (tx_err)
   );

   sbf_rx_side #(.DATA_W(DATA_W), .SLOTS(SLOTS)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (ctl.rx_flush),
      .len2      (ctl.rx_len2),
      .hang_off  (ctl.hang_off),
      .eng_push  (eng_rx_push),
      .eng_data  (eng_rx_data),
      .host_rd   (host_rx_rd),
      .host_valid(rx_valid),
      .host_head (rx_head),
      .level     (rx_level),
      .irq       (rx_irq),
      .err       (rx_err),
      .eng_full  (eng_rx_full),
      .eng_stall (eng_rx_stall)
   );

   generate
      if (ZERO_WHEN_EMPTY) begin : g_gate
         assign eng_tx_data  = eng_tx_valid ? tx_head : '0;
         assign host_rx_data = rx_valid     ? rx_head : '0;
      end else begin : g_raw
         assign eng_tx_data  = tx_head;
         assign host_rx_data = rx_head;
      end
   endgenerate

   // R5 / R9: flush answers differ per direction
   a_r5_tx_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl.tx_flush) && ctl.tx_flush |-> !eng_tx_valid && tx_level == LVL_EMPTY)
      else $error("tx flush not reported empty");

   a_r9_rx_flush_full: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl.rx_flush) && ctl.rx_flush |-> eng_rx_full && !eng_rx_stall && rx_level == LVL_EMPTY)
      else $error("rx flush not reported full");

endmodule

// File: tb/sbf_pair_tb.sv
module sbf_pair_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] ctl_rdata;
   logic        host_tx_wr = 1'b0;
   logic [7:0]  host_tx_data = '0;
   logic        host_rx_rd = 1'b0;
   logic [7:0]  host_rx_data;
   logic        eng_tx_pop = 1'b0;
   logic        eng_tx_valid;
   logic [7:0]  eng_tx_data;
   logic        eng_rx_push = 1'b0;
   logic [7:0]  eng_rx_data = '0;
   logic        eng_rx_full, eng_rx_stall;
   logic [1:0]  tx_level, rx_level;
   logic        tx_irq, rx_irq, tx_err, rx_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sbf_pair dut_i (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
      .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
      .eng_tx_pop(eng_tx_pop), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .eng_rx_full(eng_rx_full), .eng_rx_stall(eng_rx_stall),
      .tx_level(tx_level), .rx_level(rx_level),
      .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_err(tx_err), .rx_err(rx_err)
   );

   typedef struct packed {
      logic [3:0] req;
      logic       cw;  logic [4:0] cd;
      logic       tw;  logic [7:0] td;
      logic       tp;
      logic       rp;  logic [7:0] rd;
      logic       rr;
      logic [1:0] txl; logic [1:0] rxl;
      logic       txi; logic rxi;
      logic [7:0] txd; logic [7:0] rxd;
      logic       txe; logic rxe;
      logic       stl; logic ful;
   } vec_t;

   localparam int NV = 29;
   // req, cw,cd, tw,td, tp, rp,rd, rr | txl,rxl,txi,rxi,txd,rxd,txe,rxe,stall,full
   localparam vec_t VEC [NV] = '{
      '{4'd3, 1'b0,5'h00, 1'b1,8'hA1, 1'b0, 1'b0,8'h00, 1'b0, 2'b01,2'b00,1'b1,1'b0,8'hA1,8'h00,1'b0,1'b0,1'b0,1'b0}, // R3
      '{4'd3, 1'b0,5'h00, 1'b1,8'hB2, 1'b0, 1'b0,8'h00, 1'b0, 2'b11,2'b00,1'b0,1'b0,8'hA1,8'h00,1'b0,1'b0,1'b0,1'b0}, // R3 R4
      '{4'd3, 1'b0,5'h00, 1'b0,8'h00, 1'b1, 1'b0,8'h00, 1'b0, 2'b01,2'b00,1'b1,1'b0,8'hB2,8'h00,1'b0,1'b0,1'b0,1'b0}, // R3 order
      '{4'd4, 1'b1,5'h04, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b0, 2'b01,2'b00,1'b0,1'b0,8'hB2,8'h00,1'b0,1'b0,1'b0,1'b0}, // R4 len2
      '{4'd4, 1'b0,5'h00, 1'b0,8'h00, 1'b1, 1'b0,8'h00, 1'b0, 2'b00,2'b00,1'b1,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0}, // R4
      '{4'd7, 1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b1,8'h11, 1'b0, 2'b00,2'b01,1'b1,1'b1,8'h00,8'h11,1'b0,1'b0,1'b0,1'b0}, // R7 R8
      '{4'd8, 1'b1,5'h08, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b0, 2'b00,2'b01,1'b1,1'b0,8'h00,8'h11,1'b0,1'b0,1'b0,1'b0}, // R8 len2
      '{4'd8, 1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b1,8'h22, 1'b0, 2'b00,2'b11,1'b1,1'b1,8'h00,8'h11,1'b0,1'b0,1'b1,1'b1}, // R8 R11
      '{4'd11,1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b1,8'h33, 1'b0, 2'b00,2'b11,1'b1,1'b1,8'h00,8'h11,1'b0,1'b0,1'b1,1'b1}, // R11 stall
      '{4'd7, 1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b1, 2'b00,2'b01,1'b1,1'b0,8'h00,8'h22,1'b0,1'b0,1'b0,1'b0}, // R7 order
      '{4'd7, 1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b1, 2'b00,2'b00,1'b1,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0}, // R7
      '{4'd10,1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b1, 2'b00,2'b00,1'b1,1'b0,8'h00,8'h00,1'b0,1'b1,1'b0,1'b0}, // R10
      '{4'd12,1'b1,5'h10, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b0, 2'b00,2'b00,1'b1,1'b0,8'h00,8'h00,1'b0,1'b1,1'b0,1'b0}, // R12 setup
      '{4'd12,1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b1,8'h44, 1'b0, 2'b00,2'b01,1'b1,1'b1,8'h00,8'h44,1'b0,1'b1,1'b0,1'b0}, // R12
      '{4'd12,1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b1,8'h55, 1'b0, 2'b00,2'b11,1'b1,1'b1,8'h00,8'h44,1'b0,1'b1,1'b0,1'b1}, // R12 no stall
      '{4'd12,1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b1,8'h66, 1'b0, 2'b00,2'b11,1'b1,1'b1,8'h00,8'h55,1'b0,1'b1,1'b0,1'b1}, // R12 overwrite
      '{4'd12,1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b1, 2'b00,2'b01,1'b1,1'b1,8'h00,8'h66,1'b0,1'b1,1'b0,1'b0}, // R12 new order
      '{4'd6, 1'b0,5'h00, 1'b1,8'h77, 1'b0, 1'b0,8'h00, 1'b0, 2'b01,2'b01,1'b1,1'b1,8'h77,8'h66,1'b0,1'b1,1'b0,1'b0}, // R6
      '{4'd6, 1'b0,5'h00, 1'b1,8'h88, 1'b0, 1'b0,8'h00, 1'b0, 2'b11,2'b01,1'b0,1'b1,8'h77,8'h66,1'b0,1'b1,1'b0,1'b0}, // R6
      '{4'd6, 1'b0,5'h00, 1'b1,8'h99, 1'b0, 1'b0,8'h00, 1'b0, 2'b11,2'b01,1'b0,1'b1,8'h77,8'h66,1'b1,1'b1,1'b0,1'b0}, // R6 full write
      '{4'd6, 1'b0,5'h00, 1'b0,8'h00, 1'b1, 1'b0,8'h00, 1'b0, 2'b01,2'b01,1'b1,1'b1,8'h88,8'h66,1'b1,1'b1,1'b0,1'b0}, // R6 99 dropped
      '{4'd5, 1'b1,5'h11, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b0, 2'b00,2'b01,1'b1,1'b1,8'h00,8'h66,1'b1,1'b1,1'b0,1'b0}, // R5 flush on
      '{4'd5, 1'b0,5'h00, 1'b1,8'hAA, 1'b1, 1'b0,8'h00, 1'b0, 2'b00,2'b01,1'b1,1'b1,8'h00,8'h66,1'b1,1'b1,1'b0,1'b0}, // R5 held
      '{4'd5, 1'b1,5'h10, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b0, 2'b00,2'b01,1'b1,1'b1,8'h00,8'h66,1'b1,1'b1,1'b0,1'b0}, // R5 released
      '{4'd9, 1'b1,5'h12, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b0, 2'b00,2'b00,1'b1,1'b0,8'h00,8'h00,1'b1,1'b1,1'b0,1'b1}, // R9 flush on
      '{4'd9, 1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b1,8'hBB, 1'b0, 2'b00,2'b00,1'b1,1'b0,8'h00,8'h00,1'b1,1'b1,1'b0,1'b1}, // R9 push dropped
      '{4'd9, 1'b1,5'h00, 1'b0,8'h00, 1'b0, 1'b0,8'h00, 1'b0, 2'b00,2'b00,1'b1,1'b0,8'h00,8'h00,1'b1,1'b1,1'b0,1'b0}, // R9 released
      '{4'd5, 1'b0,5'h00, 1'b1,8'hCC, 1'b0, 1'b0,8'h00, 1'b0, 2'b01,2'b00,1'b1,1'b0,8'hCC,8'h00,1'b1,1'b1,1'b0,1'b0}, // R5 refill
      '{4'd9, 1'b0,5'h00, 1'b0,8'h00, 1'b0, 1'b1,8'hDD, 1'b0, 2'b01,2'b01,1'b1,1'b1,8'hCC,8'hDD,1'b1,1'b1,1'b0,1'b0}  // R9 refill
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [25:0] observe();
      return {tx_level, rx_level, tx_irq, rx_irq, eng_tx_data, host_rx_data,
              tx_err, rx_err, eng_rx_stall, eng_rx_full};
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", 32'(observe()), 32'({2'b00, 2'b00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}));
      check("R1", 32'(ctl_rdata), 32'h0);
      check("R1", 32'(eng_tx_valid), 32'h0);

      // R2 reserved bits read zero, used bits load
      ctl_wr = 1'b1; ctl_wdata = 16'hFFE5;
      @(negedge clk);
      ctl_wr = 1'b0;
      check("R2", 32'(ctl_rdata), 32'h0005);
      ctl_wr = 1'b1; ctl_wdata = 16'h0000;
      @(negedge clk);
      ctl_wr = 1'b0;
      check("R2", 32'(ctl_rdata), 32'h0000);

      for (int k = 0; k < NV; k++) begin
         ctl_wr       = VEC[k].cw;
         ctl_wdata    = {11'h0, VEC[k].cd};
         host_tx_wr   = VEC[k].tw;
         host_tx_data = VEC[k].td;
         eng_tx_pop   = VEC[k].tp;
         eng_rx_push  = VEC[k].rp;
         eng_rx_data  = VEC[k].rd;
         host_rx_rd   = VEC[k].rr;
         @(negedge clk);
         ctl_wr = 1'b0; host_tx_wr = 1'b0; eng_tx_pop = 1'b0;
         eng_rx_push = 1'b0; host_rx_rd = 1'b0;
         check($sformatf("R%0d step %0d", VEC[k].req, k), 32'(observe()),
               32'({VEC[k].txl, VEC[k].rxl, VEC[k].txi, VEC[k].rxi, VEC[k].txd,
                    VEC[k].rxd, VEC[k].txe, VEC[k].rxe, VEC[k].stl, VEC[k].ful}));
      end

      // R5 engine sees valid data again after release
      check("R5", 32'(eng_tx_valid), 32'h1);

      // R11 stall with hang enabled, read relieves it
      eng_rx_push = 1'b1; eng_rx_data = 8'hEE;
      @(negedge clk);
      eng_rx_push = 1'b0;
      check("R11", 32'({eng_rx_stall, eng_rx_full, rx_level}), 32'({1'b1, 1'b1, 2'b11}));
      host_rx_rd = 1'b1;
      @(negedge clk);
      host_rx_rd = 1'b0;
      check("R11", 32'({eng_rx_stall, host_rx_data}), 32'({1'b0, 8'hEE}));

      // R1 reset mid-run clears flags, control and contents
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'(observe()), 32'({2'b00, 2'b00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}));
      check("R1", 32'(ctl_rdata), 32'h0);

      done = 1'b1;
      finish_run();
   end

endmodule